// File: doc/BRIEF.md
# Auto-Acknowledge Receive Controller

This block runs the acknowledgment phase that follows a packet transmission. When the transmitter reports that a packet is done, the controller looks at the per-entry auto-acknowledge setting and the NO_ACK bit that was sent. If no acknowledgment is wanted, it reports success at once. Otherwise it starts a tick counter. It turns the receiver on when the counter reaches a programmed turn-on time and searches for sync until a second programmed time. It then parses the incoming acknowledgment packet byte by byte.

Parsing checks an optional address byte against the entry that was used for transmission. It then reads a one-byte header. The payload length comes either from that header, bounded by a per-entry maximum, or from the per-entry fixed length. When the packet ends, the CRC verdict from the external CRC engine settles the outcome: success, failure with an optional FIFO flush, or the overflow path. In the overflow path the packet was dropped from the Rx FIFO but was still received to its end. That path raises an interrupt and leaves a retransmission pending. The received sequence bits are recorded in a status byte but never affect acceptance.

The RF front end, the Rx FIFO and the CRC engine sit outside this block. The block drives a byte store enable and a discard command towards the FIFO and samples its full flag.

Top module: `ackrx_ctrl`

## Requirements
- R1: When tx_done is sampled while the block is idle and either the entry's auto-ack bit is 0 or tx_no_ack is 1, ack_ok is high in the cycle after that edge, rx_enable stays low, and retx_pending is cleared.
- R2: When an ack is required, rx_enable goes high at the (rx_on_time+1)-th rising edge after the edge that sampled tx_done, and not before.
- R3: If no sync_found is seen while searching, rx_enable falls and ack_fail pulses at the (search_end_time+1)-th edge after the tx_done edge.
- R4: With cfg_addr_en = 1, the first byte after sync is compared with the transmitting entry's address. A mismatch abandons the packet and resumes sync search, after which further bytes are not stored.
- R5: In variable-length mode the header byte's bits [5:0] are the payload length. A value above the entry's limit abandons the packet and resumes sync search. A value equal to the limit is accepted.
- R6: In fixed-length mode the header's length bits are ignored and exactly the entry's configured number of payload bytes is taken before the packet end is awaited.
- R7: At packet end (crc_valid), status_res is written with bit 7 = crc_ok, bits [1:0] = header bits [7:6] (sequence) and other bits 0. The sequence value does not affect acceptance.
- R8: A packet ending with crc_ok = 0 gives ack_fail. It also gives a one-cycle fifo_discard when cfg_autoflush = 1, and no discard when cfg_autoflush = 0.
- R9: If rx_fifo_full is seen during a packet, fifo_discard pulses once in the following cycle. rx_store stays low for the rest of that packet, and parsing still runs to the packet end.
- R10: After an overflow, a packet that would have been flushed anyway (crc_ok = 0 with autoflush) ends as a plain ack_fail without rxfull_irq. Any other packet ends with rxfull_irq and ack_fail together, even when its CRC is good.
- R11: ack_ok and ack_fail are never high together. ack_ok clears retx_pending, every ack_fail sets it, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_done | input | 1 | Transmission finished pulse |
| tx_entry | input | 3 | Entry index used for the transmission |
| tx_no_ack | input | 1 | NO_ACK bit that was transmitted |
| cfg_auto_ack | input | 8 | Per-entry auto-acknowledge enable |
| cfg_var_len | input | 8 | Per-entry variable-length mode |
| cfg_addr_flat | input | 64 | Per-entry address bytes, entry i at bits [8i+7:8i] |
| cfg_len_flat | input | 48 | Per-entry length (limit or fixed), entry i at bits [6i+5:6i] |
| cfg_addr_en | input | 1 | Address byte present in the ack packet |
| cfg_autoflush | input | 1 | Flush the Rx FIFO on a bad CRC |
| rx_on_time | input | 16 | Receiver turn-on tick after tx_done |
| search_end_time | input | 16 | Sync search deadline tick after tx_done |
| sync_found | input | 1 | Sync detected strobe |
| rx_byte_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| crc_valid | input | 1 | Packet end strobe with CRC verdict |
| crc_ok | input | 1 | CRC verdict |
| rx_fifo_full | input | 1 | Rx FIFO full flag |
| rx_enable | output | 1 | Receiver on (search or receive) |
| rx_store | output | 1 | Write enable for the current byte into the Rx FIFO |
| ack_ok | output | 1 | Acknowledgment accepted pulse |
| ack_fail | output | 1 | Acknowledgment lost pulse |
| fifo_discard | output | 1 | Discard-packet command to the Rx FIFO |
| rxfull_irq | output | 1 | Rx FIFO overflow error interrupt pulse |
| retx_pending | output | 1 | Next transmission must be a retransmission |
| status_res | output | 8 | Result byte of the last completed ack packet |

## Verification
The bound checker watches on every cycle that the outcome pulses are exclusive and keep retx_pending consistent. It also checks that the fast no-ack path answers in one cycle, that the overflow interrupt always comes with a failure, and that no byte is stored after an overflow discard or while the receiver is off. The exact turn-on and deadline cycles, the address and length filters, the fixed-length byte count, the status byte contents and the choice between the overflow interrupt and a plain flush depend on programmed values and byte sequences. Only the directed scenarios of the bench can show those.

// File: rtl/ackrx_pkg.sv
package ackrx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SEARCH,
      ST_ADDR,
      ST_HDR,
      ST_PAY,
      ST_CRC
   } ackrx_state_e;
endpackage

// File: rtl/ackrx_timer.sv
module ackrx_timer #(
   parameter int TIMER_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [TIMER_W-1:0] on_time,
   input  logic [TIMER_W-1:0] end_time,
   output logic               on_reached,
   output logic               end_reached
);
   logic [TIMER_W-1:0] tick_q;

   // saturating tick counter, zeroed by the start pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tick_q <= '0;
      else if (start)            tick_q <= '0;
      else if (tick_q != '1)     tick_q <= tick_q + 1'b1;
   end

   assign on_reached  = (tick_q >= on_time);
   assign end_reached = (tick_q >= end_time);
endmodule

// File: rtl/ackrx_cfg_sel.sv
module ackrx_cfg_sel #(
   parameter int N_ENTRIES = 8,
   parameter int BYTE_W    = 8,
   parameter int LEN_W     = 6,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic [IDX_W-1:0]           sel,
   input  logic [N_ENTRIES*BYTE_W-1:0] addr_flat,
   input  logic [N_ENTRIES*LEN_W-1:0]  len_flat,
   input  logic [N_ENTRIES-1:0]        var_len,
   output logic [BYTE_W-1:0]           sel_addr,
   output logic [LEN_W-1:0]            sel_len,
   output logic                        sel_var
);
   logic [BYTE_W-1:0] addr_arr [N_ENTRIES];
   logic [LEN_W-1:0]  len_arr  [N_ENTRIES];

   for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_unpack
      assign addr_arr[gi] = addr_flat[gi*BYTE_W +: BYTE_W];
      assign len_arr[gi]  = len_flat[gi*LEN_W +: LEN_W];
   end

   assign sel_addr = addr_arr[sel];
   assign sel_len  = len_arr[sel];
   assign sel_var  = var_len[sel];
endmodule

// File: rtl/ackrx_fsm.sv
module ackrx_fsm
   import ackrx_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int BYTE_W    = 8,
   parameter int LEN_W     = 6,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_done,
   input  logic [IDX_W-1:0]  tx_entry,
   input  logic              need_ack,
   input  logic              on_reached,
   input  logic              end_reached,
   input  logic              sync_found,
   input  logic              rx_byte_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              addr_match,
   input  logic [LEN_W-1:0]  sel_len,
   input  logic              sel_var,
   input  logic              crc_valid,
   input  logic              crc_ok,
   input  logic              rx_fifo_full,
   input  logic              cfg_addr_en,
   input  logic              cfg_autoflush,
   output logic [IDX_W-1:0]  ent_idx,
   output logic              timer_start,
   output logic              busy,
   output logic              rx_enable,
   output logic              rx_store,
   output logic              ack_ok,
   output logic              ack_fail,
   output logic              fifo_discard,
   output logic              rxfull_irq,
   output logic              retx_pending,
   output logic [BYTE_W-1:0] status_res
);
   ackrx_state_e     st_q;
   logic [LEN_W-1:0] rem_q;
   logic [1:0]       seq_q;
   logic             ovf_q;

   logic [LEN_W-1:0] hdr_len;
   logic [LEN_W-1:0] eff_len;
   logic             in_pkt;
   logic             takes_bytes;
   logic             drop_anyway;
   logic [BYTE_W-1:0] status_n;

   assign hdr_len     = rx_byte[LEN_W-1:0];
   assign eff_len     = sel_var ? hdr_len : sel_len;
   assign in_pkt      = (st_q == ST_ADDR) || (st_q == ST_HDR) ||
                        (st_q == ST_PAY)  || (st_q == ST_CRC);
   assign takes_bytes = (st_q == ST_ADDR) || (st_q == ST_HDR) || (st_q == ST_PAY);
   assign drop_anyway = !crc_ok && cfg_autoflush;

   assign busy        = (st_q != ST_IDLE);
   assign timer_start = tx_done && (st_q == ST_IDLE) && need_ack;
   assign rx_enable   = (st_q == ST_SEARCH) || in_pkt;
   assign rx_store    = rx_byte_valid && takes_bytes && !ovf_q && !rx_fifo_full;

   always_comb begin
      status_n           = '0;
      status_n[BYTE_W-1] = crc_ok;
      status_n[1:0]      = seq_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         ent_idx      <= '0;
         rem_q        <= '0;
         seq_q        <= '0;
         ovf_q        <= 1'b0;
         ack_ok       <= 1'b0;
         ack_fail     <= 1'b0;
         fifo_discard <= 1'b0;
         rxfull_irq   <= 1'b0;
         retx_pending <= 1'b0;
         status_res   <= '0;
      end else begin
         ack_ok       <= 1'b0;
         ack_fail     <= 1'b0;
         fifo_discard <= 1'b0;
         rxfull_irq   <= 1'b0;
         // overflow: drop the packet from the FIFO once, keep parsing
         if (in_pkt && rx_fifo_full && !ovf_q) begin
            ovf_q        <= 1'b1;
            fifo_discard <= 1'b1;
         end
         case (st_q)
            ST_IDLE: if (tx_done) begin
               ent_idx <= tx_entry;
               if (need_ack) st_q <= ST_WAIT;
               else begin
                  ack_ok       <= 1'b1;
                  retx_pending <= 1'b0;
               end
            end
            ST_WAIT: if (on_reached) st_q <= ST_SEARCH;
            ST_SEARCH: begin
               if (sync_found) begin
                  ovf_q <= 1'b0;
                  st_q  <= cfg_addr_en ? ST_ADDR : ST_HDR;
               end else if (end_reached) begin
                  ack_fail     <= 1'b1;
                  retx_pending <= 1'b1;
                  st_q         <= ST_IDLE;
               end
            end
            ST_ADDR: if (rx_byte_valid) st_q <= addr_match ? ST_HDR : ST_SEARCH;
            ST_HDR: if (rx_byte_valid) begin
               seq_q <= rx_byte[BYTE_W-1 -: 2];
               if (sel_var && (hdr_len > sel_len)) st_q <= ST_SEARCH;
               else begin
                  rem_q <= eff_len;
                  st_q  <= (eff_len == '0) ? ST_CRC : ST_PAY;
               end
            end
            ST_PAY: if (rx_byte_valid) begin
               rem_q <= rem_q - 1'b1;
               if (rem_q == LEN_W'(1)) st_q <= ST_CRC;
            end
            ST_CRC: if (crc_valid) begin
               status_res <= status_n;
               st_q       <= ST_IDLE;
               if (ovf_q && !drop_anyway) begin
                  rxfull_irq   <= 1'b1;
                  ack_fail     <= 1'b1;
                  retx_pending <= 1'b1;
               end else if (crc_ok) begin
                  ack_ok       <= 1'b1;
                  retx_pending <= 1'b0;
               end else begin
                  ack_fail     <= 1'b1;
                  retx_pending <= 1'b1;
                  fifo_discard <= cfg_autoflush && !ovf_q;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ackrx_ctrl.sv
module ackrx_ctrl #(
   parameter int N_ENTRIES      = 8,
   parameter int BYTE_W         = 8,
   parameter int LEN_W          = 6,
   parameter int MAX_LEN        = 32,
   parameter int TIMER_W        = 16,
   parameter bit ADDR_FILTER_EN = 1'b1,
   localparam int IDX_W         = $clog2(N_ENTRIES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tx_done,
   input  logic [IDX_W-1:0]            tx_entry,
   input  logic                        tx_no_ack,
   input  logic [N_ENTRIES-1:0]        cfg_auto_ack,
   input  logic [N_ENTRIES-1:0]        cfg_var_len,
   input  logic [N_ENTRIES*BYTE_W-1:0] cfg_addr_flat,
   input  logic [N_ENTRIES*LEN_W-1:0]  cfg_len_flat,
   input  logic                        cfg_addr_en,
   input  logic                        cfg_autoflush,
   input  logic [TIMER_W-1:0]          rx_on_time,
   input  logic [TIMER_W-1:0]          search_end_time,
   input  logic                        sync_found,
   input  logic                        rx_byte_valid,
   input  logic [BYTE_W-1:0]           rx_byte,
   input  logic                        crc_valid,
   input  logic                        crc_ok,
   input  logic                        rx_fifo_full,
   output logic                        rx_enable,
   output logic                        rx_store,
   output logic                        ack_ok,
   output logic                        ack_fail,
   output logic                        fifo_discard,
   output logic                        rxfull_irq,
   output logic                        retx_pending,
   output logic [BYTE_W-1:0]           status_res
);
   if (N_ENTRIES < 2)             begin : g_bad_n   $error("N_ENTRIES must be at least 2"); end
   if (BYTE_W < LEN_W + 2)        begin : g_bad_w   $error("BYTE_W must hold length and sequence"); end
   if (MAX_LEN >= (1 << LEN_W))   begin : g_bad_len $error("MAX_LEN must fit in LEN_W"); end
   if (TIMER_W < 2)               begin : g_bad_t   $error("TIMER_W too small"); end

   logic [IDX_W-1:0]  ent_idx;
   logic [BYTE_W-1:0] sel_addr;
   logic [LEN_W-1:0]  sel_len;
   logic              sel_var;
   logic              addr_match;
   logic              need_ack;
   logic              timer_start;
   logic              on_reached;
   logic              end_reached;
   logic              busy;

   assign need_ack = cfg_auto_ack[tx_entry] && !tx_no_ack;

   ackrx_cfg_sel #(.N_ENTRIES(N_ENTRIES), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) sel_i (
      .sel(ent_idx), .addr_flat(cfg_addr_flat), .len_flat(cfg_len_flat),
      .var_len(cfg_var_len), .sel_addr(sel_addr), .sel_len(sel_len), .sel_var(sel_var)
   );

   if (ADDR_FILTER_EN) begin : g_addr_cmp
      assign addr_match = (rx_byte == sel_addr);
   end else begin : g_addr_any
      logic unused_addr;
      assign unused_addr = ^sel_addr;
      assign addr_match  = 1'b1;
   end

   ackrx_timer #(.TIMER_W(TIMER_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .start(timer_start),
      .on_time(rx_on_time), .end_time(search_end_time),
      .on_reached(on_reached), .end_reached(end_reached)
   );

   ackrx_fsm #(.N_ENTRIES(N_ENTRIES), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_entry(tx_entry),
      .need_ack(need_ack), .on_reached(on_reached), .end_reached(end_reached),
      .sync_found(sync_found), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
      .addr_match(addr_match), .sel_len(sel_len), .sel_var(sel_var),
      .crc_valid(crc_valid), .crc_ok(crc_ok), .rx_fifo_full(rx_fifo_full),
      .cfg_addr_en(cfg_addr_en), .cfg_autoflush(cfg_autoflush),
      .ent_idx(ent_idx), .timer_start(timer_start), .busy(busy),
      .rx_enable(rx_enable), .rx_store(rx_store), .ack_ok(ack_ok),
      .ack_fail(ack_fail), .fifo_discard(fifo_discard), .rxfull_irq(rxfull_irq),
      .retx_pending(retx_pending), .status_res(status_res)
   );
endmodule

// File: rtl/ackrx_ctrl_chk.sv
module ackrx_ctrl_chk #(
   parameter int N_ENTRIES = 8,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tx_done,
   input logic [IDX_W-1:0]     tx_entry,
   input logic                 tx_no_ack,
   input logic [N_ENTRIES-1:0] cfg_auto_ack,
   input logic                 busy,
   input logic                 rx_enable,
   input logic                 rx_store,
   input logic                 ack_ok,
   input logic                 ack_fail,
   input logic                 fifo_discard,
   input logic                 rxfull_irq,
   input logic                 retx_pending
);
   a_r1_noack_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && !busy && (tx_no_ack || !cfg_auto_ack[tx_entry])) |=> ack_ok);

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_ok && ack_fail));

   a_r11_ok_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_ok |-> !retx_pending);

   a_r11_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fail |-> retx_pending);

   a_r10_irq_fails: assert property (@(posedge clk) disable iff (!rst_n)
      rxfull_irq |-> ack_fail);

   a_r9_no_store_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_discard && !ack_fail) |=> !rx_store);

   a_r2_store_needs_rx: assert property (@(posedge clk) disable iff (!rst_n)
      rx_store |-> rx_enable);
endmodule

bind ackrx_ctrl ackrx_ctrl_chk #(.N_ENTRIES(N_ENTRIES)) chk_i (
   .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_entry(tx_entry),
   .tx_no_ack(tx_no_ack), .cfg_auto_ack(cfg_auto_ack), .busy(busy),
   .rx_enable(rx_enable), .rx_store(rx_store), .ack_ok(ack_ok),
   .ack_fail(ack_fail), .fifo_discard(fifo_discard), .rxfull_irq(rxfull_irq),
   .retx_pending(retx_pending)
);

// File: tb/ackrx_ctrl_tb.sv
`timescale 1ns/1ps
module ackrx_ctrl_tb_top;
   localparam int T_ON  = 3;
   localparam int T_END = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_done = 1'b0;
   logic [2:0]  tx_entry = '0;
   logic        tx_no_ack = 1'b0;
   logic [7:0]  cfg_auto_ack;
   logic [7:0]  cfg_var_len;
   logic [63:0] cfg_addr_flat;
   logic [47:0] cfg_len_flat;
   logic        cfg_addr_en = 1'b1;
   logic        cfg_autoflush = 1'b1;
   logic [15:0] rx_on_time = 16'(T_ON);
   logic [15:0] search_end_time = 16'(T_END);
   logic        sync_found = 1'b0;
   logic        rx_byte_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        crc_valid = 1'b0;
   logic        crc_ok = 1'b0;
   logic        rx_fifo_full = 1'b0;
   logic        rx_enable, rx_store, ack_ok, ack_fail, fifo_discard, rxfull_irq, retx_pending;
   logic [7:0]  status_res;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic last_store;

   always #2.5 clk = ~clk;

   ackrx_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_entry(tx_entry),
      .tx_no_ack(tx_no_ack), .cfg_auto_ack(cfg_auto_ack), .cfg_var_len(cfg_var_len),
      .cfg_addr_flat(cfg_addr_flat), .cfg_len_flat(cfg_len_flat),
      .cfg_addr_en(cfg_addr_en), .cfg_autoflush(cfg_autoflush),
      .rx_on_time(rx_on_time), .search_end_time(search_end_time),
      .sync_found(sync_found), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
      .crc_valid(crc_valid), .crc_ok(crc_ok), .rx_fifo_full(rx_fifo_full),
      .rx_enable(rx_enable), .rx_store(rx_store), .ack_ok(ack_ok),
      .ack_fail(ack_fail), .fifo_discard(fifo_discard), .rxfull_irq(rxfull_irq),
      .retx_pending(retx_pending), .status_res(status_res)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic send_tx(input logic [2:0] ent, input logic noack);
      tx_entry = ent; tx_no_ack = noack; tx_done = 1'b1;
      tick();
      tx_done = 1'b0; tx_no_ack = 1'b0;
   endtask

   task automatic start_ack(input logic [2:0] ent);
      send_tx(ent, 1'b0);
      repeat (T_ON + 1) tick();
      sync_found = 1'b1;
      tick();
      sync_found = 1'b0;
   endtask

   task automatic feed(input logic [7:0] b);
      rx_byte = b; rx_byte_valid = 1'b1;
      #1 last_store = rx_store;
      tick();
      rx_byte_valid = 1'b0;
   endtask

   task automatic finish_pkt(input logic ok);
      crc_ok = ok; crc_valid = 1'b1;
      tick();
      crc_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R11", "retx after reset", retx_pending, 0);
      check("R1", "ack_ok after reset", ack_ok, 0);
      check("R2", "rx_enable after reset", rx_enable, 0);
   endtask

   task automatic t_noack();
      send_tx(3'd0, 1'b0);
      check("R1", "auto-ack off gives ack_ok", ack_ok, 1);
      check("R1", "rx stays off", rx_enable, 0);
      tick();
      send_tx(3'd1, 1'b1);
      check("R1", "NO_ACK set gives ack_ok", ack_ok, 1);
      check("R1", "retx cleared", retx_pending, 0);
   endtask

   task automatic t_timeout();
      send_tx(3'd1, 1'b0);
      for (int k = 1; k <= T_END + 1; k++) begin
         tick();
         if (k == T_ON)      check("R2", "rx off before on time", rx_enable, 0);
         if (k == T_ON + 1)  check("R2", "rx on at on time", rx_enable, 1);
         if (k == T_END)     check("R3", "no fail before deadline", ack_fail, 0);
         if (k == T_END + 1) begin
            check("R3", "fail at deadline", ack_fail, 1);
            check("R3", "rx off at deadline", rx_enable, 0);
            check("R11", "retx set by timeout", retx_pending, 1);
         end
      end
   endtask

   task automatic t_good();
      start_ack(3'd1);
      feed(8'hA5);
      check("R4", "address stored", last_store, 1);
      feed(8'h84);
      for (int i = 0; i < 4; i++) feed(8'(i));
      check("R5", "payload at limit stored", last_store, 1);
      finish_pkt(1'b1);
      check("R5", "len at limit accepted", ack_ok, 1);
      check("R7", "status byte", status_res, 8'h82);
      check("R11", "retx cleared by ok", retx_pending, 0);
   endtask

   task automatic t_addr_mismatch();
      start_ack(3'd1);
      feed(8'h5A);
      feed(8'h00);
      check("R4", "byte after mismatch not stored", last_store, 0);
      check("R4", "still searching", rx_enable, 1);
      sync_found = 1'b1; tick(); sync_found = 1'b0;
      feed(8'hA5);
      feed(8'h00);
      finish_pkt(1'b1);
      check("R4", "retry after mismatch accepted", ack_ok, 1);
   endtask

   task automatic t_len_abort();
      bit seen;
      start_ack(3'd1);
      feed(8'hA5);
      feed(8'h05);
      feed(8'h11);
      check("R5", "over-limit payload not stored", last_store, 0);
      seen = 1'b0;
      for (int k = 0; k < 60 && !seen; k++) begin
         if (ack_ok) check("R5", "over-limit packet accepted", 1, 0);
         if (ack_fail) seen = 1'b1;
         else tick();
      end
      check("R5", "over-limit ends in timeout", seen, 1);
   endtask

   task automatic t_fixed();
      start_ack(3'd2);
      feed(8'h3C);
      feed(8'h7F);
      feed(8'hAA);
      feed(8'hBB);
      check("R6", "second fixed byte stored", last_store, 1);
      feed(8'hCC);
      check("R6", "byte beyond fixed length not stored", last_store, 0);
      finish_pkt(1'b1);
      check("R6", "fixed length accepted", ack_ok, 1);
      check("R7", "status seq 01", status_res, 8'h81);
   endtask

   task automatic t_crc_bad(input logic flush);
      cfg_autoflush = flush;
      start_ack(3'd2);
      feed(8'h3C); feed(8'h00); feed(8'h01); feed(8'h02);
      finish_pkt(1'b0);
      check("R8", "bad crc fails", ack_fail, 1);
      check("R8", "discard follows autoflush", fifo_discard, flush);
      check("R7", "status msb clear", status_res[7], 0);
      check("R10", "no irq without overflow", rxfull_irq, 0);
      cfg_autoflush = 1'b1;
   endtask

   task automatic t_ovf(input logic ok, input logic flush, input logic exp_irq);
      cfg_autoflush = flush;
      start_ack(3'd1);
      feed(8'hA5); feed(8'h04); feed(8'h10);
      rx_fifo_full = 1'b1;
      feed(8'h11);
      rx_fifo_full = 1'b0;
      check("R9", "full byte not stored", last_store, 0);
      check("R9", "discard on overflow", fifo_discard, 1);
      feed(8'h12);
      check("R9", "no store after overflow", last_store, 0);
      check("R9", "no second discard", fifo_discard, 0);
      feed(8'h13);
      check("R9", "still receiving", rx_enable, 1);
      finish_pkt(ok);
      check("R10", "irq choice", rxfull_irq, exp_irq);
      check("R10", "ack lost", ack_fail, 1);
      check("R10", "no ack_ok", ack_ok, 0);
      check("R11", "retx pending", retx_pending, 1);
      cfg_autoflush = 1'b1;
   endtask

   initial begin
      cfg_auto_ack  = 8'b0000_0110;
      cfg_var_len   = 8'b0000_0010;
      cfg_addr_flat = '0;
      cfg_addr_flat[15:8]  = 8'hA5;
      cfg_addr_flat[23:16] = 8'h3C;
      cfg_len_flat  = '0;
      cfg_len_flat[11:6]  = 6'd4;
      cfg_len_flat[17:12] = 6'd2;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_noack();        tick();
      t_timeout();      tick();
      t_good();         tick();
      t_addr_mismatch(); tick();
      t_len_abort();    tick();
      t_fixed();        tick();
      t_crc_bad(1'b1);  tick();
      t_crc_bad(1'b0);  tick();
      t_ovf(1'b1, 1'b1, 1'b1); tick();
      t_ovf(1'b0, 1'b1, 1'b0); tick();
      t_ovf(1'b0, 1'b0, 1'b1); tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule